// File: doc/BRIEF.md
# Transmit Character Queue Host Write Port

This block is the host-facing write side of a small transmit character queue. A host selects the port with an active-low chip select, strobes a write enable, and presents 10-bit characters. The port qualifies each strobe, stores accepted characters in a 16-entry queue, and raises an early-warning full flag while headroom is still left. A downstream consumer drains the queue through a plain read strobe.

A single mode input sets the polarity of the write enable and of the full flag. It also picks between same-edge and next-cycle data capture. A queue reset is started only by a request that is held, with the port otherwise quiet, for seven clocks in a row. The reset then clears the write side first and the read side second. A bypass input replaces the queue with a single holding register. In bypass the flag shows whether that register is occupied, or, with double-rate clocking, toggles as a character-rate reference.

Top module: `txh_host_wr`

## Requirements
- R1: A write strobe is honoured only if `cs_n` was sampled low on the clock edge before the strobe's edge. A strobe in the first cycle of select does nothing.
- R2: With `mode_hi`=0, `wen` is active low, and `wdata` is stored on the same edge at which `wen` is sampled low.
- R3: With `mode_hi`=1, `wen` is active high, and the stored character is the `wdata` value present on the edge after the one that sampled `wen` high.
- R4: In queue mode the internal full condition is true when 12 or more of the 16 entries are occupied (four or fewer free). It is false at 11 or fewer.
- R5: `full_flag` reads 0 when asserted if `mode_hi`=0, and reads 1 when asserted if `mode_hi`=1.
- R6: A write that arrives while the internal full condition is true is discarded, and `ovf` becomes 1 and stays 1 until `rst_n`.
- R7: A queue reset begins only after seven consecutive edges with `bypass`=0, `wen` inactive, `cs_n`=0 and `rst_req_n`=0. Six such edges followed by a break leave the contents intact.
- R8: A reset clears the write pointer and then the read pointer, leaving the queue empty. The full condition is held true from the start of the reset until `rst_req_n` returns high.
- R9: With `bypass`=1, `rst_req_n` has no effect. The full condition equals the occupancy of the one-character holding register, which is written by a qualified strobe and emptied by `rd_en`.
- R10: With `bypass`=1 and `dbl_rate`=1, the full condition inverts on every clock, so its period is one character time of two clocks.
- R11: Characters leave through `rd_data` in the order they were accepted. `rd_empty` is 1 when nothing is stored or a reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| mode_hi | input | 1 | Polarity and capture-timing select |
| bypass | input | 1 | 1 replaces the queue with a holding register |
| dbl_rate | input | 1 | Double-rate reference clocking in bypass |
| cs_n | input | 1 | Active-low chip select |
| wen | input | 1 | Write enable, polarity set by `mode_hi` |
| wdata | input | 10 | Character to write |
| rst_req_n | input | 1 | Active-low queue reset request |
| rd_en | input | 1 | Consumer pop strobe |
| rd_data | output | 10 | Head character |
| rd_empty | output | 1 | Nothing available to read |
| full_flag | output | 1 | Full/busy flag, polarity set by `mode_hi` |
| ovf | output | 1 | Sticky discarded-write indicator |

## Verification
In the low-polarity mode, writes are driven with the select raised one cycle before the strobe and then held. This separates a port that checks the previous cycle's select from one that checks the current cycle's. In the high-polarity mode, writes present a decoy value in the strobe cycle and the real value one cycle later, so a design that captures on the wrong cycle returns the decoy. Reset requests are held for six and then for seven qualifying cycles, which exposes an off-by-one in the qualification count. The queue is filled to exactly 11 and 12 entries and then pushed one past, which pins down the warning threshold and the discard rule.

// File: rtl/txh_pkg.sv
package txh_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_WCLR = 2'd1,
    RS_RCLR = 2'd2,
    RS_HOLD = 2'd3
  } rs_state_e;

  // occupancy from wrap-bit pointers
  function automatic int fill_level(input int wp, input int rp, input int depth);
    return (wp + 2 * depth - rp) % (2 * depth);
  endfunction

  // warning when free slots fall to the margin or below
  function automatic logic headroom_low(input int lvl, input int depth, input int margin);
    return (lvl + margin) >= depth;
  endfunction

endpackage

// File: rtl/txh_qual.sv
module txh_qual #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_hi,
  input  logic          cs_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wen_act,
  output logic          wr_req,
  output logic [DW-1:0] wr_data
);

  logic cs_q;
  logic pend_q;
  logic sel;

  assign wen_act = mode_hi ? wen : ~wen;
  assign sel     = wen_act & cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cs_q   <= ~cs_n;
      pend_q <= mode_hi & sel;
    end
  end

  assign wr_req  = mode_hi ? pend_q : sel;
  assign wr_data = wdata;

  // R1
  sel_prev_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && wr_req) |-> $past(!cs_n));

  // R3
  late_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && $past(mode_hi) && wr_req) |-> $past(wen));

endmodule

// File: rtl/txh_rstseq.sv
module txh_rstseq
  import txh_pkg::*;
#(
  parameter int QUAL = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bypass,
  input  logic      wen_act,
  input  logic      cs_n,
  input  logic      req_n,
  output rs_state_e state,
  output logic      clr_wr,
  output logic      clr_rd,
  output logic      busy
);

  localparam int CW = $clog2(QUAL + 1);
  localparam int RW = $clog2(QUAL + 2);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL - 1);

  logic          qual;
  logic [CW-1:0] cnt_q;

  assign qual = ~bypass & ~wen_act & ~cs_n & ~req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_IDLE;
      cnt_q <= '0;
    end else begin
      case (state)
        RS_IDLE: begin
          if (!qual) begin
            cnt_q <= '0;
          end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            state <= RS_WCLR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RS_WCLR: state <= RS_RCLR;
        RS_RCLR: state <= RS_HOLD;
        default: if (req_n) state <= RS_IDLE;
      endcase
    end
  end

  assign clr_wr = (state == RS_WCLR);
  assign clr_rd = (state == RS_RCLR);
  assign busy   = (state != RS_IDLE);

  // independent run counter for the checker
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_q <= '0;
    else if (!qual)                     run_q <= '0;
    else if (run_q != RW'(QUAL + 1))    run_q <= run_q + 1'b1;
  end

  // R7
  qual_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_wr) |-> (run_q >= RW'(QUAL)));

  // R8
  clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |-> $past(clr_wr));

  // R8
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_n) |=> busy);

endmodule

// File: rtl/txh_store.sv
module txh_store
  import txh_pkg::*;
#(
  parameter int DW     = 10,
  parameter int DEPTH  = 16,
  parameter int MARGIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          clr_wr,
  input  logic          clr_rd,
  input  logic          lock,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          near_full
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q;
  logic [PW-1:0] rptr_q;
  int            lvl;
  logic          pop;

  assign lvl       = fill_level(int'(wptr_q), int'(rptr_q), DEPTH);
  assign near_full = headroom_low(lvl, DEPTH, MARGIN);
  assign empty     = lock || (lvl == 0);
  assign pop       = rd_en && !empty;
  assign rd_data   = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (clr_wr)     wptr_q <= '0;
      else if (wr_en) wptr_q <= wptr_q + 1'b1;
      if (clr_rd)     rptr_q <= '0;
      else if (pop)   rptr_q <= rptr_q + 1'b1;
    end
  end

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (lvl <= DEPTH));

endmodule

// File: rtl/txh_host_wr.sv
module txh_host_wr
  import txh_pkg::*;
#(
  parameter int DW     = 10,
  parameter int DEPTH  = 16,
  parameter int MARGIN = 4,
  parameter int QUAL   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_hi,
  input  logic          bypass,
  input  logic          dbl_rate,
  input  logic          cs_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic          rst_req_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          full_flag,
  output logic          ovf
);

  logic          wen_act;
  logic          wr_req;
  logic [DW-1:0] wr_data;
  rs_state_e     rs_state;
  logic          clr_wr, clr_rd, seq_busy;
  logic [DW-1:0] q_rd_data;
  logic          q_empty, q_near_full;

  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic          tog_q;

  logic q_flag, flag_act, acc_q, acc_b, drop;

  txh_qual #(.DW(DW)) u_qual (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .cs_n(cs_n), .wen(wen),
    .wdata(wdata), .wen_act(wen_act), .wr_req(wr_req), .wr_data(wr_data)
  );

  txh_rstseq #(.QUAL(QUAL)) u_seq (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .wen_act(wen_act),
    .cs_n(cs_n), .req_n(rst_req_n), .state(rs_state),
    .clr_wr(clr_wr), .clr_rd(clr_rd), .busy(seq_busy)
  );

  assign q_flag = seq_busy || q_near_full;
  assign acc_q  = wr_req && !bypass && !q_flag;
  assign acc_b  = wr_req && bypass && !hold_v;
  assign drop   = wr_req && !acc_q && !acc_b;

  txh_store #(.DW(DW), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_q), .wr_data(wr_data),
    .rd_en(rd_en && !bypass), .clr_wr(clr_wr), .clr_rd(clr_rd),
    .lock(seq_busy), .rd_data(q_rd_data), .empty(q_empty),
    .near_full(q_near_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      tog_q  <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (acc_b) begin
        hold_v <= 1'b1;
        hold_d <= wr_data;
      end else if (bypass && rd_en) begin
        hold_v <= 1'b0;
      end
      tog_q <= (bypass && dbl_rate) ? ~tog_q : 1'b0;
      if (drop) ovf <= 1'b1;
    end
  end

  always_comb begin
    if (!bypass)      flag_act = q_flag;
    else if (dbl_rate) flag_act = tog_q;
    else              flag_act = hold_v;
  end

  assign full_flag = mode_hi ? flag_act : ~flag_act;
  assign rd_data   = bypass ? hold_d : q_rd_data;
  assign rd_empty  = bypass ? ~hold_v : q_empty;

  // R6
  discard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);

  // R6
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);

  // R9
  byp_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !seq_busy) |=> !seq_busy);

  // R10
  byp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && dbl_rate && $past(bypass && dbl_rate)) |-> (tog_q != $past(tog_q)));

endmodule

// File: tb/txh_host_wr_tb.sv
module txh_host_wr_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_hi = 1'b0;
  logic       bypass = 1'b0;
  logic       dbl_rate = 1'b0;
  logic       cs_n = 1'b0;
  logic       wen = 1'b1;
  logic [9:0] wdata = '0;
  logic       rst_req_n = 1'b1;
  logic       rd_en = 1'b0;
  logic [9:0] rd_data;
  logic       rd_empty, full_flag, ovf;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  txh_host_wr u_dut (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .bypass(bypass),
    .dbl_rate(dbl_rate), .cs_n(cs_n), .wen(wen), .wdata(wdata),
    .rst_req_n(rst_req_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .full_flag(full_flag), .ovf(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // pin level that means "full" in the current mode
  function automatic int asserted_lvl();
    return mode_hi ? 1 : 0;
  endfunction

  task automatic idle_wen();
    wen = mode_hi ? 1'b0 : 1'b1;
  endtask

  task automatic wr(input logic [9:0] d);
    if (!mode_hi) begin
      @(negedge clk); wen = 1'b0; wdata = d;
      @(negedge clk); wen = 1'b1;
    end else begin
      @(negedge clk); wen = 1'b1; wdata = ~d;
      @(negedge clk); wen = 1'b0; wdata = d;
      @(negedge clk);
    end
  endtask

  task automatic rd(output logic [9:0] d);
    @(negedge clk); d = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R11 empty after reset", rd_empty, 1);
    chk("R6 ovf clear after reset", ovf, 0);
    chk("R5 flag idle level low mode", full_flag, 1);
  endtask

  task automatic t_select();
    logic [9:0] d;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0; wen = 1'b0; wdata = 10'h2A5;
    @(negedge clk);
    // R1 first-cycle strobe ignored
    chk("R1 no write in first select cycle", rd_empty, 1);
    @(negedge clk); wen = 1'b1;
    chk("R1 write once select seen", rd_empty, 0);
    rd(d);
    chk("R1 data", d, 10'h2A5);
  endtask

  task automatic t_low_mode();
    wr(10'h011);
    chk("R2 stored on strobe edge", rd_empty, 0);
    chk("R2 head data", rd_data, 10'h011);
    wr(10'h022);
    wr(10'h033);
  endtask

  task automatic t_reset_seq();
    logic [9:0] d;
    @(negedge clk); rst_req_n = 1'b0;
    repeat (6) @(negedge clk);
    rst_req_n = 1'b1;
    @(negedge clk);
    chk("R7 six cycles keep contents", rd_empty, 0);
    chk("R7 six cycles no flag", full_flag, 1);
    rst_req_n = 1'b0;
    repeat (7) @(negedge clk);
    chk("R8 flag during reset", full_flag, 0);
    repeat (5) @(negedge clk);
    chk("R8 flag held with request", full_flag, 0);
    chk("R11 empty during reset", rd_empty, 1);
    rst_req_n = 1'b1;
    @(negedge clk);
    chk("R8 flag released", full_flag, 1);
    chk("R8 queue cleared", rd_empty, 1);
    wr(10'h044);
    rd(d);
    chk("R8 pointers coherent after reset", d, 10'h044);
  endtask

  task automatic t_high_mode();
    @(negedge clk); mode_hi = 1'b1; idle_wen();
    @(negedge clk); wen = 1'b1; wdata = 10'h3C3;
    @(negedge clk); wen = 1'b0; wdata = 10'h05A;
    chk("R3 not stored on strobe edge", rd_empty, 1);
    @(negedge clk);
    chk("R3 stored next edge", rd_empty, 0);
    chk("R3 next-cycle data", rd_data, 10'h05A);
    begin
      logic [9:0] d;
      rd(d);
    end
  endtask

  task automatic t_fill();
    logic [9:0] d;
    for (int i = 0; i < 11; i++) wr(10'(100 + i));
    chk("R4 eleven not full", full_flag, 0);
    wr(10'(111));
    chk("R4 twelve full", full_flag, asserted_lvl());
    chk("R6 no ovf yet", ovf, 0);
    wr(10'h3FF);
    chk("R6 discard sets ovf", ovf, 1);
    @(negedge clk); mode_hi = 1'b0; idle_wen();
    @(negedge clk);
    chk("R5 low-mode asserted level", full_flag, 0);
    mode_hi = 1'b1; idle_wen();
    @(negedge clk);
    chk("R5 high-mode asserted level", full_flag, 1);
    for (int i = 0; i < 12; i++) begin
      rd(d);
      chk("R11 order", d, 100 + i);
    end
    chk("R6 discarded not stored", rd_empty, 1);
    chk("R6 ovf sticky", ovf, 1);
  endtask

  task automatic t_bypass();
    logic [9:0] d;
    @(negedge clk); bypass = 1'b1;
    @(negedge clk);
    chk("R9 ready when empty", full_flag, 0);
    wr(10'h155);
    chk("R9 busy when held", full_flag, 1);
    chk("R9 held data", rd_data, 10'h155);
    @(negedge clk); rst_req_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 reset ignored flag", full_flag, 1);
    chk("R9 reset ignored data", rd_data, 10'h155);
    rst_req_n = 1'b1;
    rd(d);
    chk("R9 read value", d, 10'h155);
    chk("R9 ready after read", full_flag, 0);
  endtask

  task automatic t_toggle();
    int prev;
    @(negedge clk); dbl_rate = 1'b1;
    @(negedge clk); prev = full_flag;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 toggles each clock", full_flag, 1 - prev);
      prev = full_flag;
    end
    dbl_rate = 1'b0; bypass = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_select();
    t_low_mode();
    t_reset_seq();
    t_high_mode();
    t_fill();
    t_bypass();
    t_toggle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule